// File: doc/BRIEF.md
# Read/Write Strobe Handshake Controller

This controller sits between a bus master and a peripheral device. It serves one transfer at a time as a four-phase handshake on both sides. The master asks for a read or a write by raising one of two strobes. The controller then strobes the device, enables the data transceiver in the correct phase, and acknowledges the master. For the return to zero, it waits for the master to drop its strobe and for the device to drop its acknowledge.

The design is clocked. All three inputs pass through a synchronizer chain before the state machine sees them. Every output comes straight from a flop, so it cannot glitch. Several phases of a cycle show the same output values, so an internal coding bit tells the set half of a cycle from its reset half. If the master or the device breaks the expected order, the controller latches a sticky error flag and freezes its outputs until reset.

Top module: `hs_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `dev_strb_o`, `data_en_o`, `bus_ack_o`, `proto_err_o` and the internal coding bit become 0.
- R2: A read cycle drives the output vector {dev_strb_o, data_en_o, bus_ack_o} through exactly 000, 100, 110, 111, 101, 000. Here 100 waits for `dev_ack_i` high and 111 waits for `rd_strb_i` low. `bus_ack_o` rises only while `dev_strb_o` is high and after the device has acknowledged.
- R3: A write cycle drives the same vector through exactly 000, 010, 110, 100, 101, 000. Here 110 waits for `dev_ack_i` high and 101 waits for `wr_strb_i` low. In a write, `data_en_o` rises while `dev_strb_o` is still low.
- R4: From idle, the strobe that is high alone selects the cycle: `rd_strb_i` starts a read and `wr_strb_i` starts a write.
- R5: The internal coding bit is set at least one clock before `dev_strb_o` rises. It is cleared only together with the strobe fall, once `data_en_o` is low and both bus strobes have been seen low.
- R6: `dev_strb_o` never rises while the synchronized `dev_ack_i` is high. A new strobe that arrives while the device still acknowledges the previous cycle waits until `dev_ack_i` has fallen.
- R7: `proto_err_o` is set and stays set until reset if any of the following happens: `dev_ack_i` is high in idle; both strobes are high in idle; the other strobe rises during a cycle; a strobe falls before `bus_ack_o`; or `dev_ack_i` falls before the device strobe is released.
- R8: While `proto_err_o` is high, none of the three handshake outputs changes, whatever the inputs do.
- R9: With `SYNC_STAGES` = 2, a write strobe raised in idle shows on `data_en_o` after exactly 3 rising clock edges, and a read strobe shows on `dev_strb_o` after exactly 4.
- R10: At most one handshake output changes per clock. The single exception is that `dev_strb_o` and `bus_ack_o` fall together at the end of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_strb_i | input | 1 | Bus read strobe (asynchronous) |
| wr_strb_i | input | 1 | Bus write strobe (asynchronous) |
| dev_ack_i | input | 1 | Device acknowledge (asynchronous) |
| dev_strb_o | output | 1 | Strobe to the device |
| data_en_o | output | 1 | Transceiver data enable |
| bus_ack_o | output | 1 | Acknowledge to the bus master |
| proto_err_o | output | 1 | Sticky protocol violation flag |

## Verification
Some properties are checked by assertions on every clock:
- the device strobe never rises against a high acknowledge;
- the coding bit leads the strobe rise and clears only once the strobes and the enable are low;
- the bus acknowledge is gated by the device acknowledge;
- only one output changes per clock, except the paired strobe and acknowledge fall;
- the error flag is sticky and the outputs freeze while it is set.

The complete edge order of read, write and mixed back-to-back cycles cannot be checked cycle by cycle, nor can the synchronizer latency or the response to each specific illegal order. Only the bench's reactive master and device scenarios show these.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_R_ARM  = 4'd1,
    ST_R_STRB = 4'd2,
    ST_R_EN   = 4'd3,
    ST_R_ACK  = 4'd4,
    ST_R_DROP = 4'd5,
    ST_W_EN   = 4'd6,
    ST_W_STRB = 4'd7,
    ST_W_DROP = 4'd8,
    ST_W_ACK  = 4'd9,
    ST_RET    = 4'd10,
    ST_FAULT  = 4'd11
  } hs_state_t;

  typedef struct packed {
    logic strb;
    logic en;
    logic ack;
    logic csc;
  } hs_outs_t;

  // Output values and coding bit held in each phase
  function automatic hs_outs_t outs_of(input hs_state_t s);
    hs_outs_t o;
    o = '0;
    case (s)
      ST_R_ARM:  o = '{strb: 1'b0, en: 1'b0, ack: 1'b0, csc: 1'b1};
      ST_R_STRB: o = '{strb: 1'b1, en: 1'b0, ack: 1'b0, csc: 1'b1};
      ST_R_EN:   o = '{strb: 1'b1, en: 1'b1, ack: 1'b0, csc: 1'b1};
      ST_R_ACK:  o = '{strb: 1'b1, en: 1'b1, ack: 1'b1, csc: 1'b1};
      ST_R_DROP: o = '{strb: 1'b1, en: 1'b0, ack: 1'b1, csc: 1'b1};
      ST_W_EN:   o = '{strb: 1'b0, en: 1'b1, ack: 1'b0, csc: 1'b1};
      ST_W_STRB: o = '{strb: 1'b1, en: 1'b1, ack: 1'b0, csc: 1'b1};
      ST_W_DROP: o = '{strb: 1'b1, en: 1'b0, ack: 1'b0, csc: 1'b1};
      ST_W_ACK:  o = '{strb: 1'b1, en: 1'b0, ack: 1'b1, csc: 1'b1};
      default:   o = '0;
    endcase
    return o;
  endfunction

  function automatic logic is_read(input hs_state_t s);
    return (s == ST_R_ARM) || (s == ST_R_STRB) || (s == ST_R_EN) ||
           (s == ST_R_ACK) || (s == ST_R_DROP);
  endfunction

  function automatic logic is_write(input hs_state_t s);
    return (s == ST_W_EN) || (s == ST_W_STRB) || (s == ST_W_DROP) ||
           (s == ST_W_ACK);
  endfunction

  // Illegal input combination for the current phase
  function automatic logic fault_of(input hs_state_t s, input logic rd,
                                    input logic wr, input logic ack);
    logic f;
    f = 1'b0;
    if (is_read(s) && wr)  f = 1'b1;
    if (is_write(s) && rd) f = 1'b1;
    case (s)
      ST_IDLE:   if (ack || (rd && wr)) f = 1'b1;
      ST_R_ARM:  if (ack || !rd)        f = 1'b1;
      ST_R_STRB: if (!rd)               f = 1'b1;
      ST_R_EN:   if (!rd || !ack)       f = 1'b1;
      ST_R_ACK:  if (!ack)              f = 1'b1;
      ST_R_DROP: if (rd || !ack)        f = 1'b1;
      ST_W_EN:   if (ack || !wr)        f = 1'b1;
      ST_W_STRB: if (!wr)               f = 1'b1;
      ST_W_DROP: if (!wr || !ack)       f = 1'b1;
      ST_W_ACK:  if (!ack)              f = 1'b1;
      default:   f = f;
    endcase
    return f;
  endfunction

  // Legal successor when no fault is present
  function automatic hs_state_t advance_of(input hs_state_t s, input logic rd,
                                           input logic wr, input logic ack);
    hs_state_t n;
    n = s;
    case (s)
      ST_IDLE:   if (rd) n = ST_R_ARM; else if (wr) n = ST_W_EN;
      ST_R_ARM:  n = ST_R_STRB;
      ST_R_STRB: if (ack) n = ST_R_EN;
      ST_R_EN:   n = ST_R_ACK;
      ST_R_ACK:  if (!rd) n = ST_R_DROP;
      ST_R_DROP: n = ST_RET;
      ST_W_EN:   n = ST_W_STRB;
      ST_W_STRB: if (ack) n = ST_W_DROP;
      ST_W_DROP: n = ST_W_ACK;
      ST_W_ACK:  if (!wr) n = ST_RET;
      ST_RET:    if (!ack) n = ST_IDLE;
      default:   n = s;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/1ps
module hs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '0;
        else     chain[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hs_fsm.sv
`timescale 1ns/1ps
module hs_fsm
  import hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rd,
  input  logic      wr,
  input  logic      ack,
  output hs_state_t state_q,
  output hs_state_t state_d,
  output logic      fault_ev
);
  always_comb begin
    fault_ev = 1'b0;
    state_d  = state_q;
    if (state_q != ST_FAULT) begin
      fault_ev = fault_of(state_q, rd, wr, ack);
      state_d  = fault_ev ? ST_FAULT : advance_of(state_q, rd, wr, ack);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/hs_drive.sv
`timescale 1ns/1ps
module hs_drive
  import hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  hs_state_t state_d,
  output logic      strb_q,
  output logic      en_q,
  output logic      ack_q,
  output logic      csc_q,
  output logic      err_q
);
  hs_outs_t nxt;
  logic     freeze;

  assign nxt    = outs_of(state_d);
  assign freeze = (state_d == ST_FAULT);

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q <= 1'b0;
      en_q   <= 1'b0;
      ack_q  <= 1'b0;
      csc_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (freeze) begin
      err_q  <= 1'b1;
    end else begin
      strb_q <= nxt.strb;
      en_q   <= nxt.en;
      ack_q  <= nxt.ack;
      csc_q  <= nxt.csc;
    end
  end
endmodule

// File: rtl/hs_ctrl.sv
`timescale 1ns/1ps
module hs_ctrl
  import hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_strb_i,
  input  logic wr_strb_i,
  input  logic dev_ack_i,
  output logic dev_strb_o,
  output logic data_en_o,
  output logic bus_ack_o,
  output logic proto_err_o
);
  localparam int IN_W = 3;

  logic [IN_W-1:0] raw_in;
  logic [IN_W-1:0] sync_in;
  logic            rd_sync;
  logic            wr_sync;
  logic            ack_sync;
  logic            csc_bit;
  logic            fault_ev;
  hs_state_t       state_q;
  hs_state_t       state_d;

  assign raw_in = {rd_strb_i, wr_strb_i, dev_ack_i};
  assign {rd_sync, wr_sync, ack_sync} = sync_in;

  hs_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw_in),
    .dout(sync_in)
  );

  hs_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .rd      (rd_sync),
    .wr      (wr_sync),
    .ack     (ack_sync),
    .state_q (state_q),
    .state_d (state_d),
    .fault_ev(fault_ev)
  );

  hs_drive u_drive (
    .clk    (clk),
    .rst    (rst),
    .state_d(state_d),
    .strb_q (dev_strb_o),
    .en_q   (data_en_o),
    .ack_q  (bus_ack_o),
    .csc_q  (csc_bit),
    .err_q  (proto_err_o)
  );
endmodule

// File: rtl/hs_ctrl_chk.sv
`timescale 1ns/1ps
module hs_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic rd_s,
  input logic wr_s,
  input logic ack_s,
  input logic fault_ev,
  input logic dev_strb,
  input logic data_en,
  input logic bus_ack,
  input logic csc_q,
  input logic proto_err
);
  logic [2:0] outs;
  assign outs = {dev_strb, data_en, bus_ack};

  // R6
  strb_after_ack_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_strb) |-> $past(!ack_s));

  // R5
  csc_before_strb_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_strb) |-> (csc_q && $past(csc_q)));

  // R5
  csc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(csc_q) |-> (!dev_strb && !data_en && $past(!rd_s && !wr_s)));

  // R2
  ack_needs_dev_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ack) |-> (dev_strb && $past(ack_s)));

  // R3
  wr_first_en_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(data_en) && !dev_strb) |-> $past(wr_s));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(proto_err) |-> $past(fault_ev));

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $stable(outs));

  // R10
  single_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(outs ^ $past(outs)) > 1) |->
      (!dev_strb && !bus_ack && !data_en && $past(dev_strb) && $past(bus_ack)));
endmodule

bind hs_ctrl hs_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_s     (rd_sync),
  .wr_s     (wr_sync),
  .ack_s    (ack_sync),
  .fault_ev (fault_ev),
  .dev_strb (dev_strb_o),
  .data_en  (data_en_o),
  .bus_ack  (bus_ack_o),
  .csc_q    (csc_bit),
  .proto_err(proto_err_o)
);

// File: tb/sim_hs_ctrl.sv
`timescale 1ns/1ps
module sim_hs_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd = 1'b0, wr = 1'b0, ack = 1'b0;
  logic dev_strb, data_en, bus_ack, proto_err;
  int   tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  hs_ctrl u0 (
    .clk(clk), .rst(rst), .rd_strb_i(rd), .wr_strb_i(wr), .dev_ack_i(ack),
    .dev_strb_o(dev_strb), .data_en_o(data_en), .bus_ack_o(bus_ack),
    .proto_err_o(proto_err)
  );

  wire [2:0] outv = {dev_strb, data_en, bus_ack};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Wait for the output vector to move from 'from' directly to 'to'
  task automatic step(input logic [2:0] from, input logic [2:0] to, input string req);
    bit done = 0, bad = 0;
    int n = 0;
    while (!done && !bad) begin
      @(negedge clk);
      n++;
      if (outv == to) done = 1;
      else if (outv != from || n > 60) bad = 1;
    end
    chk(done, req, "edge order", {1'b0, outv}, {1'b0, to});
  endtask

  task automatic gap();
    repeat ($urandom_range(0, 5)) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; rd = 0; wr = 0; ack = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({outv, proto_err} == 4'b0000, "R1", "reset state", {outv, proto_err}, 4'b0000);
  endtask

  task automatic release_dev();
    gap(); ack = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_front();
    gap(); ack = 1'b1;
    step(3'b100, 3'b110, "R2");
    step(3'b110, 3'b111, "R2");
    gap(); rd = 1'b0;
    step(3'b111, 3'b101, "R2");
    step(3'b101, 3'b000, "R10");
  endtask

  task automatic write_front();
    step(3'b010, 3'b110, "R3");
    gap(); ack = 1'b1;
    step(3'b110, 3'b100, "R3");
    step(3'b100, 3'b101, "R3");
    gap(); wr = 1'b0;
    step(3'b101, 3'b000, "R10");
  endtask

  task automatic do_read();
    rd = 1'b1;
    step(3'b000, 3'b100, "R4");
    read_front();
    release_dev();
  endtask

  task automatic do_write();
    wr = 1'b1;
    step(3'b000, 3'b010, "R4");
    write_front();
    release_dev();
  endtask

  task automatic expect_fault(input logic [2:0] held, input string req);
    bit seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (proto_err) seen = 1;
    end
    chk(seen && outv == held, req, "fault latched, outputs",
        {outv, proto_err}, {held, 1'b1});
  endtask

  task automatic expect_frozen(input logic [2:0] held);
    int bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (outv != held || !proto_err) bad++;
    end
    chk(bad == 0, "R8", "outputs frozen in fault", {outv, proto_err}, {held, 1'b1});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();

    // R9: synchronizer latency, write then read
    @(negedge clk); wr = 1'b1;
    repeat (2) @(negedge clk);
    chk(outv == 3'b000, "R9", "write before 3rd edge", {1'b0, outv}, 4'b0000);
    @(negedge clk);
    chk(outv == 3'b010, "R9", "write at 3rd edge", {1'b0, outv}, 4'b0010);
    write_front(); release_dev();

    @(negedge clk); rd = 1'b1;
    repeat (3) @(negedge clk);
    chk(outv == 3'b000, "R9", "read before 4th edge", {1'b0, outv}, 4'b0000);
    @(negedge clk);
    chk(outv == 3'b100, "R9", "read at 4th edge", {1'b0, outv}, 4'b0100);
    read_front(); release_dev();

    // Back-to-back and mixed cycles
    do_read(); do_read(); do_write(); do_write();
    for (int k = 0; k < 24; k++) begin
      if ($urandom_range(0, 1) == 0) do_read(); else do_write();
    end

    // R6: next strobe while device still acknowledges
    rd = 1'b1;
    step(3'b000, 3'b100, "R6");
    read_front();
    gap(); rd = 1'b1;
    begin
      int early = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (dev_strb) early++;
      end
      chk(early == 0 && !proto_err, "R6", "strobe held off",
          {early[2:0], proto_err}, 4'b0000);
    end
    ack = 1'b0;
    step(3'b000, 3'b100, "R6");
    read_front(); release_dev();
    chk(!proto_err, "R7", "no fault on legal traffic", {3'b0, proto_err}, 4'b0000);

    // R7/R8: acknowledge high in idle
    ack = 1'b1;
    expect_fault(3'b000, "R7");
    rd = 1'b1; ack = 1'b0;
    expect_frozen(3'b000);
    do_reset();

    // R7: both strobes together
    rd = 1'b1; wr = 1'b1;
    expect_fault(3'b000, "R7");
    do_reset();

    // R7/R8: acknowledge drops while bus acknowledge is high
    rd = 1'b1;
    step(3'b000, 3'b100, "R2");
    ack = 1'b1;
    step(3'b100, 3'b110, "R2");
    step(3'b110, 3'b111, "R2");
    ack = 1'b0;
    expect_fault(3'b111, "R7");
    rd = 1'b0;
    expect_frozen(3'b111);
    do_reset();

    // R7: read strobe appears during a write
    wr = 1'b1;
    step(3'b000, 3'b010, "R3");
    step(3'b010, 3'b110, "R3");
    rd = 1'b1;
    expect_fault(3'b110, "R7");
    do_reset();

    // R7: read strobe withdrawn before the device acknowledges
    rd = 1'b1;
    step(3'b000, 3'b100, "R2");
    rd = 1'b0;
    expect_fault(3'b100, "R7");
    ack = 1'b1;
    expect_frozen(3'b100);
    do_reset();

    do_write(); do_read();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule